// File: doc/BRIEF.md
# Power-on RAM size detector

This engine runs once after reset, ahead of the processor, and works out how many page (high address) lines a byte-wide single-port synchronous SRAM actually decodes. It probes offset zero of page 1, then page 2, then 4 and onward, one address line at a time. Each probed byte is read, written back inverted, and read again to catch stuck bits. It is then inverted once more so that its original value returns. A warm restart therefore finds memory as it was, apart from two scratch bytes at addresses 0 and 1.

Sizing does not fill memory with a pattern. Every probe also leaves its inverted byte at address 0 as a reference. Once the probe is restored, the engine compares it with address 0. If the two now agree, the probe page has folded back onto page 0, which means the address line under test does not exist. The reported top page is then the page index just below the probe. A failed read-back sends the engine into a terminal failure state that it leaves only through reset.

Top module: `ramsize_top`

## Requirements
- R1: After reset, and until `start` is pulsed, `done`, `fail` and `memWe` are all low.
- R2: Every write outside addresses 0 and 1 lands at offset 0 of a page whose index has exactly one bit set. The probed pages rise 1, 2, 4, ... and there are at most PAGE_W probes.
- R3: Before each probe, the probe page value is written to address 1. After completion, address 1 holds the last page probed.
- R4: Each inverted probe value is also written to address 0 on the cycle right after the probe write, with the same data.
- R5: If the read-back of a probe differs from the inverted value just written, `fail` rises and stays high, and `done` never rises. A stuck bit at a location that is never probed does not cause a failure.
- R6: After normal completion, every byte at an address of 2 or above holds its value from before `start`.
- R7: If the probe at page P aliases onto address 0, `done` rises and `topPage` equals P-1. If only page 0 exists, this gives 0.
- R8: If all PAGE_W probes pass without aliasing, `done` rises and `topPage` is all ones.
- R9: `done` and `fail` are never high together. While either is high, `memWe` stays low and `topPage` does not change.
- R10: `start` pulses after completion or failure change neither the outputs nor memory.
- R11: SRAM read data is taken one cycle after its address is presented, with no write in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts the sizing run; used only in the idle state |
| memAddr | output | PAGE_W+OFF_W | SRAM address, {page, offset} |
| memWdata | output | DATA_W | SRAM write data |
| memWe | output | 1 | SRAM write enable |
| memRdata | input | DATA_W | SRAM read data, valid one cycle after the address |
| done | output | 1 | Sizing finished normally |
| fail | output | 1 | Stuck bit found; held until reset |
| topPage | output | PAGE_W | Highest page index present |

## Verification
The bench builds the engine with PAGE_W=4 and OFF_W=2, so the whole 64-byte address space fits in a bench SRAM model. In that model the number of decoded page lines can be set anywhere from 0 to 4, which lets a sweep reach every aliasing point and also the full-range case. Each fill pattern gives a restore check over every byte, and the scratch contents at addresses 0 and 1 can be predicted exactly. Stuck-bit injection at a probed page and at an unprobed page covers both the failure path and its negative case.

// File: rtl/ramsize_pkg.sv
package ramsize_pkg;

  typedef enum logic [1:0] {
    AS_ZERO  = 2'd0,
    AS_ONE   = 2'd1,
    AS_PROBE = 2'd2
  } addrSel_e;

  typedef enum logic {
    WD_PROBE = 1'b0,
    WD_DATA  = 1'b1
  } wdSel_e;

  typedef struct packed {
    logic     we;
    addrSel_e addrSel;
    wdSel_e   wdSel;
    logic     loadFirst;
    logic     captInv;
    logic     captNext;
    logic     setWrap;
    logic     setFull;
  } ctlStrobes_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SAVE,
    ST_READ,
    ST_INV,
    ST_WRP,
    ST_WRZ,
    ST_RB,
    ST_CMP,
    ST_RST,
    ST_RDZ,
    ST_CHK,
    ST_LDS,
    ST_NXT,
    ST_DONE,
    ST_FAIL
  } sizeState_e;

endpackage

// File: rtl/ramsize_datapath.sv
module ramsize_datapath
  import ramsize_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  ctlStrobes_t               ctl,
  input  logic [DATA_W-1:0]         memRdata,
  output logic [PAGE_W+OFF_W-1:0]   memAddr,
  output logic [DATA_W-1:0]         memWdata,
  output logic                      eqData,
  output logic                      lastProbe,
  output logic [PAGE_W-1:0]         topPage
);

  localparam int ADDR_W = PAGE_W + OFF_W;
  localparam logic [DATA_W-1:0] INV_MASK  = '1;
  localparam logic [PAGE_W-1:0] FIRST_PG  = PAGE_W'(1);
  localparam logic [PAGE_W-1:0] FULL_PG   = '1;
  localparam logic [ADDR_W-1:0] ADDR_ZERO = '0;
  localparam logic [ADDR_W-1:0] ADDR_ONE  = ADDR_W'(1);

  logic [PAGE_W-1:0] probe;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] probeWide;
  logic [PAGE_W-1:0] reloadPage;

  // Widen the page value into a data byte (or take it as is).
  generate
    if (DATA_W == PAGE_W) begin : g_noPad
      assign probeWide  = probe;
      assign reloadPage = memRdata;
    end else begin : g_pad
      assign probeWide  = {{(DATA_W-PAGE_W){1'b0}}, probe};
      assign reloadPage = memRdata[PAGE_W-1:0];
    end
  endgenerate

  // Probe page register: starts at 1, reloaded from scratch and doubled.
  always_ff @(posedge clk) begin
    if (rst) begin
      probe <= FIRST_PG;
    end else if (ctl.loadFirst) begin
      probe <= FIRST_PG;
    end else if (ctl.captNext) begin
      probe <= reloadPage << 1;
    end
  end

  // Data register holds the inverted value, then the restore value.
  always_ff @(posedge clk) begin
    if (rst) begin
      dataReg <= '0;
    end else if (ctl.captInv) begin
      dataReg <= memRdata ^ INV_MASK;
    end
  end

  // Result register.
  always_ff @(posedge clk) begin
    if (rst) begin
      topPage <= '0;
    end else if (ctl.setFull) begin
      topPage <= FULL_PG;
    end else if (ctl.setWrap) begin
      topPage <= probe - FIRST_PG;
    end
  end

  always_comb begin
    unique case (ctl.addrSel)
      AS_ONE:   memAddr = ADDR_ONE;
      AS_PROBE: memAddr = {probe, {OFF_W{1'b0}}};
      default:  memAddr = ADDR_ZERO;
    endcase
  end

  assign memWdata  = (ctl.wdSel == WD_DATA) ? dataReg : probeWide;
  assign eqData    = (memRdata == dataReg);
  assign lastProbe = reloadPage[PAGE_W-1];

  // R2: any access to the probe location uses a single page line
  a_r2_onehot_page: assert property (@(posedge clk) disable iff (rst)
    (ctl.addrSel == AS_PROBE) |-> $onehot(probe));

  // R2: a new probe page is always larger than the one before
  a_r2_page_rises: assert property (@(posedge clk) disable iff (rst)
    ctl.captNext |=> (probe > $past(probe)) || (probe == '0));

endmodule

// File: rtl/ramsize_ctrl.sv
module ramsize_ctrl
  import ramsize_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        eqData,
  input  logic        lastProbe,
  output ctlStrobes_t ctl,
  output logic        done,
  output logic        fail
);

  sizeState_e state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState     = state;
    ctl           = '0;
    ctl.addrSel   = AS_ZERO;
    ctl.wdSel     = WD_DATA;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.loadFirst = 1'b1;
          nextState     = ST_SAVE;
        end
      end
      ST_SAVE: begin
        ctl.we      = 1'b1;
        ctl.addrSel = AS_ONE;
        ctl.wdSel   = WD_PROBE;
        nextState   = ST_READ;
      end
      ST_READ: begin
        ctl.addrSel = AS_PROBE;
        nextState   = ST_INV;
      end
      ST_INV: begin
        ctl.captInv = 1'b1;
        nextState   = ST_WRP;
      end
      ST_WRP: begin
        ctl.we      = 1'b1;
        ctl.addrSel = AS_PROBE;
        nextState   = ST_WRZ;
      end
      ST_WRZ: begin
        ctl.we      = 1'b1;
        ctl.addrSel = AS_ZERO;
        nextState   = ST_RB;
      end
      ST_RB: begin
        ctl.addrSel = AS_PROBE;
        nextState   = ST_CMP;
      end
      ST_CMP: begin
        if (eqData) begin
          ctl.captInv = 1'b1;
          nextState   = ST_RST;
        end else begin
          nextState   = ST_FAIL;
        end
      end
      ST_RST: begin
        ctl.we      = 1'b1;
        ctl.addrSel = AS_PROBE;
        nextState   = ST_RDZ;
      end
      ST_RDZ: begin
        ctl.addrSel = AS_ZERO;
        nextState   = ST_CHK;
      end
      ST_CHK: begin
        if (eqData) begin
          ctl.setWrap = 1'b1;
          nextState   = ST_DONE;
        end else begin
          nextState   = ST_LDS;
        end
      end
      ST_LDS: begin
        ctl.addrSel = AS_ONE;
        nextState   = ST_NXT;
      end
      ST_NXT: begin
        if (lastProbe) begin
          ctl.setFull = 1'b1;
          nextState   = ST_DONE;
        end else begin
          ctl.captNext = 1'b1;
          nextState    = ST_SAVE;
        end
      end
      ST_DONE: nextState = ST_DONE;
      ST_FAIL: nextState = ST_FAIL;
      default: nextState = ST_IDLE;
    endcase
  end

  assign done = (state == ST_DONE);
  assign fail = (state == ST_FAIL);

  // R11: a compare state is always entered straight from its read state
  a_r11_read_then_compare: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CMP) |-> ($past(state) == ST_RB) && !$past(ctl.we));

  // R5: the failure state is only entered from a mismatching read-back
  a_r5_fail_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> ($past(state) == ST_CMP) && !$past(eqData));

endmodule

// File: rtl/ramsize_top.sv
module ramsize_top
  import ramsize_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  output logic [PAGE_W+OFF_W-1:0] memAddr,
  output logic [DATA_W-1:0]       memWdata,
  output logic                    memWe,
  input  logic [DATA_W-1:0]       memRdata,
  output logic                    done,
  output logic                    fail,
  output logic [PAGE_W-1:0]       topPage
);

  ctlStrobes_t ctl;
  logic        eqData;
  logic        lastProbe;

  ramsize_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .eqData    (eqData),
    .lastProbe (lastProbe),
    .ctl       (ctl),
    .done      (done),
    .fail      (fail)
  );

  ramsize_datapath #(
    .PAGE_W (PAGE_W),
    .OFF_W  (OFF_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .eqData    (eqData),
    .lastProbe (lastProbe),
    .topPage   (topPage)
  );

  assign memWe = ctl.we;

  // R9: final states are exclusive and silent on the SRAM
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));
  a_r9_no_write_final: assert property (@(posedge clk) disable iff (rst)
    (done || fail) |-> !memWe);
  a_r9_result_held: assert property (@(posedge clk) disable iff (rst)
    done |=> done && $stable(topPage));

  // R5: failure is sticky
  a_r5_fail_sticky: assert property (@(posedge clk) disable iff (rst)
    fail |=> fail && !done);

  // R4: the reference copy at address 0 follows the probe write with equal data
  a_r4_copy_follows: assert property (@(posedge clk) disable iff (rst)
    (memWe && memAddr == '0) |-> $past(memWe) && ($past(memWdata) == memWdata)
                                  && ($past(memAddr) != '0));

endmodule

// File: tb/ramsize_top_tb_top.sv
module ramsize_top_tb_top;

  localparam int PAGE_W = 4;
  localparam int OFF_W  = 2;
  localparam int DATA_W = 8;
  localparam int ADDR_W = PAGE_W + OFF_W;
  localparam int MEM_N  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic              memWe;
  logic [DATA_W-1:0] memRdata = '0;
  logic              done;
  logic              fail;
  logic [PAGE_W-1:0] topPage;

  always #2.5 clk = ~clk;

  ramsize_top #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .start(start),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRdata(memRdata),
    .done(done), .fail(fail), .topPage(topPage)
  );

  // SRAM model with configurable decoded page lines and one stuck bit
  logic [DATA_W-1:0] mem  [MEM_N];
  logic [DATA_W-1:0] init [MEM_N];
  int  physK = PAGE_W;
  bit  stuckOn = 0;
  int  stuckAt = 0;
  logic [DATA_W-1:0] stuckMask = '0;
  logic [DATA_W-1:0] stuckVal = '0;

  int  probeWrites = 0;
  int  badProbeAddr = 0;
  int  maxProbePage = 0;
  int  lastProbeSeen = 0;
  int  endWrites = 0;

  function automatic int phys(input logic [ADDR_W-1:0] a);
    int pg, off;
    pg  = int'(a[ADDR_W-1:OFF_W]) & ((1 << physK) - 1);
    off = int'(a[OFF_W-1:0]);
    return (pg << OFF_W) | off;
  endfunction

  always @(posedge clk) begin
    int pa;
    pa = phys(memAddr);
    memRdata <= mem[pa];
    if (memWe && !rst) begin
      if (stuckOn && pa == stuckAt)
        mem[pa] <= (memWdata & ~stuckMask) | (stuckVal & stuckMask);
      else
        mem[pa] <= memWdata;
      if (done || fail) endWrites++;
      if (memAddr > ADDR_W'(1) && memAddr != '0) begin
        int pg;
        pg = int'(memAddr[ADDR_W-1:OFF_W]);
        if (memAddr[OFF_W-1:0] != '0 || $countones(pg) != 1 || pg < lastProbeSeen)
          badProbeAddr++;
        if (pg != lastProbeSeen) begin
          probeWrites++;
          lastProbeSeen = pg;
        end
        if (pg > maxProbePage) maxProbePage = pg;
      end
    end
  end

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;

  task automatic check(input string req, input int act, input int exp, input string what);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic runCase(input int k, input int seed, input bit stuck, input int sAddr,
                         input bit expectFail);
    int waitN;
    int expTop, expLoc1, expLoc0, topPg;
    physK = k;
    stuckOn = stuck;
    stuckAt = sAddr;
    rst = 1'b1;
    for (int i = 0; i < MEM_N; i++) begin
      logic [DATA_W-1:0] v;
      v = DATA_W'((i * 37 + seed * 53 + (i >> 2) * seed + 5) & 255);
      if (seed % 3 == 0 && (i % (1 << OFF_W)) == 0) v = (seed % 2 == 0) ? 8'h00 : 8'hFF;
      mem[i]  = v;
      init[i] = v;
    end
    stuckMask = 8'h01;
    stuckVal  = init[sAddr] & 8'h01;
    probeWrites = 0; badProbeAddr = 0; maxProbePage = 0; lastProbeSeen = 0; endWrites = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R1", int'(done), 0, "done before start");
    check("R1", int'(fail), 0, "fail before start");
    check("R1", int'(memWe), 0, "write enable before start");
    pulseStart();
    waitN = 0;
    while (!(done || fail) && waitN < 4000) begin
      @(negedge clk);
      waitN++;
    end
    if (expectFail) begin
      check("R5", int'(fail), 1, "fail on stuck bit");
      check("R5", int'(done), 0, "done on stuck bit");
      pulseStart();
      repeat (20) @(negedge clk);
      check("R5", int'(fail), 1, "fail held");
      check("R10", int'(memWe) + endWrites, 0, "writes after failure");
      check("R9", int'(done), 0, "done after failure");
      return;
    end
    topPg   = (k < PAGE_W) ? (1 << k) : (1 << (PAGE_W - 1));
    expTop  = (1 << k) - 1;
    expLoc1 = topPg;
    if (k == 0) expLoc0 = int'(init[0]);
    else if (k < PAGE_W) expLoc0 = int'(~init[(1 << (k - 1)) << OFF_W]) & 255;
    else expLoc0 = int'(~init[(1 << (PAGE_W - 1)) << OFF_W]) & 255;
    check("R5", int'(fail), 0, $sformatf("no fail k=%0d", k));
    check(k < PAGE_W ? "R7" : "R8", int'(done), 1, $sformatf("done k=%0d", k));
    check(k < PAGE_W ? "R7" : "R8", int'(topPage), expTop, $sformatf("topPage k=%0d", k));
    check("R2", badProbeAddr, 0, "bad probe addresses");
    check("R2", (k >= 1) ? maxProbePage : 1, topPg, "highest probed page");
    check("R3", int'(mem[1]), expLoc1, "scratch page at address 1");
    check("R4", int'(mem[0]), expLoc0, "reference copy at address 0");
    begin
      int bad;
      bad = 0;
      for (int a = 2; a < ((1 << k) << OFF_W); a++)
        if (mem[a] !== init[a]) bad++;
      check("R6", bad, 0, $sformatf("unrestored bytes k=%0d", k));
    end
    pulseStart();
    repeat (30) @(negedge clk);
    check("R10", int'(done), 1, "done after late start");
    check("R10", int'(topPage), expTop, "topPage after late start");
    check("R9", endWrites + int'(memWe), 0, "writes after done");
    check("R9", int'(fail), 0, "fail alongside done");
  endtask

  initial begin
    for (int k = 0; k <= PAGE_W; k++)
      for (int s = 1; s <= 4; s++)
        runCase(k, s + 3 * k, 1'b0, 0, 1'b0);
    // R5: stuck bit at a probed page (page 2, offset 0)
    runCase(PAGE_W, 7, 1'b1, 2 << OFF_W, 1'b1);
    runCase(2, 9, 1'b1, 1 << OFF_W, 1'b1);
    // R5: stuck bit at a page that is never probed (page 3, offset 0)
    runCase(PAGE_W, 11, 1'b1, 3 << OFF_W, 1'b0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule